// File: doc/BRIEF.md
# Set-Associative Tag Lookup with LRU Replacement

This unit holds the tag, valid and recency state of a small cache of one-word blocks and decides, for each block number presented to it, whether that block is resident and which way it occupies or will occupy. The `WAYS` parameter selects the organisation of the same `BLOCKS` entries. With four blocks, `WAYS=1` gives four sets of one way (direct mapped), `WAYS=2` gives two sets of two ways, and `WAYS=4` gives one set of four ways (fully associative). The data payload and the timing of the backing memory are handled outside this unit.

A request is a block number qualified by `req_valid`. The low-order bits of the block number pick the set, and the remaining upper bits form the tag. The unit compares the tag against every way of that set in parallel. On a miss it allocates a way: the lowest-numbered empty way if the set has one, and otherwise the least recently used way. The response arrives one clock later. It carries the hit flag, the way number, and the tag of any valid block that the fill displaced. The accessed way becomes the most recently used way of its set in the same clock edge that captures the response, so back-to-back requests see each other's effects.

Top module: `sa_lru_cache`

## Requirements
- R1: The set is the block number modulo `BLOCKS/WAYS`, taken from its low `log2(BLOCKS/WAYS)` bits (no bits when there is one set); the sets behave independently.
- R2: The stored tag is the block number shifted right by the index width. `resp_evict_tag` reports it zero-extended to `BLK_W` bits, and it reads zero whenever `resp_evict` is low.
- R3: Each request with `req_valid` high produces `resp_valid` high on the next cycle. `resp_hit` is 1 when a valid way in the set holds the request's tag, and `resp_way` then gives that way's number.
- R4: On a miss in a set that has empty ways, the lowest-numbered empty way is filled, `resp_way` names it and `resp_evict` is 0.
- R5: On a miss in a full set, the least recently used way is replaced: `resp_way` names it, `resp_evict` is 1 and `resp_evict_tag` holds the displaced tag. A hit never evicts.
- R6: A hit and a fill each make the accessed way the most recently used way of its set.
- R7: The block sequence 0, 8, 0, 6, 8 on an empty cache of four blocks yields 5 misses when direct mapped, 4 with two ways and 3 when fully associative.
- R8: Asynchronous reset (`rst_n` low) empties every set and holds `resp_valid` low. A cycle with `req_valid` low gives `resp_valid` low and leaves all state unchanged, whatever `req_blk` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request qualifier |
| req_blk | input | BLK_W | Block number of the request |
| resp_valid | output | 1 | Response for the previous cycle's request |
| resp_hit | output | 1 | Block was resident |
| resp_way | output | max(1,log2(WAYS)) | Way that hit or was filled |
| resp_evict | output | 1 | A valid block was displaced |
| resp_evict_tag | output | BLK_W | Tag of the displaced block, zero-extended |

## Verification
Eviction of the oldest way and promotion of the incoming block to most recent take effect at the same clock edge. The ordering between them is what decides the next victim. The bench provokes this in the fully associative build: it fills all four ways, re-touches the oldest one, and then misses twice in a row. Each of the two victims must be the way that the recency order predicts, and the displaced tag must appear on the response. The same double effect is checked in the two-way build, and again in the reference sequence, where every step of 0, 8, 0, 6, 8 compares way, hit and evicted tag across all three organisations.

// File: rtl/cache_pkg.sv
package cache_pkg;
  // Width of a field that selects one of n items, never narrower than one bit.
  function automatic int width_of(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Number of block-number bits consumed by the set index (zero for one set).
  function automatic int index_bits(input int sets);
    return (sets > 1) ? $clog2(sets) : 0;
  endfunction
endpackage

// File: rtl/way_match.sv
module way_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 7,
  parameter int WAY_W = 1
) (
  input  logic             valid_row [WAYS],
  input  logic [TAG_W-1:0] tag_row   [WAYS],
  input  logic [TAG_W-1:0] req_tag,
  output logic [WAYS-1:0]  hit_vec,
  output logic             hit,
  output logic [WAY_W-1:0] hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = valid_row[w] && (tag_row[w] == req_tag);
  end

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |hit_vec;
endmodule

// File: rtl/victim_sel.sv
module victim_sel #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic             valid_row [WAYS],
  input  logic [WAY_W-1:0] age_row   [WAYS],
  output logic [WAY_W-1:0] victim_way,
  output logic             victim_full
);
  logic             any_free;
  logic [WAY_W-1:0] free_way;
  logic [WAY_W-1:0] oldest_way;

  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_row[w]) begin
        any_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
    oldest_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (age_row[w] == WAY_W'(WAYS - 1)) oldest_way = WAY_W'(w);
    end
  end

  assign victim_way  = any_free ? free_way : oldest_way;
  assign victim_full = !any_free;
endmodule

// File: rtl/lru_age.sv
module lru_age #(
  parameter int WAYS  = 2,
  parameter int WAY_W = 1
) (
  input  logic [WAY_W-1:0] age_row  [WAYS],
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] age_next [WAYS]
);
  logic [WAY_W-1:0] touch_age;

  always_comb begin
    touch_age = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (touch_way == WAY_W'(w)) touch_age = age_row[w];
    end
    for (int w = 0; w < WAYS; w++) begin
      if (touch_way == WAY_W'(w))     age_next[w] = '0;
      else if (age_row[w] < touch_age) age_next[w] = age_row[w] + WAY_W'(1);
      else                              age_next[w] = age_row[w];
    end
  end
endmodule

// File: rtl/sa_lru_cache.sv
module sa_lru_cache #(
  parameter int BLOCKS = 4,
  parameter int WAYS   = 2,
  parameter int BLK_W  = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  input  logic [BLK_W-1:0]                      req_blk,
  output logic                                  resp_valid,
  output logic                                  resp_hit,
  output logic [cache_pkg::width_of(WAYS)-1:0]  resp_way,
  output logic                                  resp_evict,
  output logic [BLK_W-1:0]                      resp_evict_tag
);
  localparam int SETS     = BLOCKS / WAYS;
  localparam int IDX_BITS = cache_pkg::index_bits(SETS);
  localparam int IDX_W    = cache_pkg::width_of(SETS);
  localparam int WAY_W    = cache_pkg::width_of(WAYS);
  localparam int TAG_W    = BLK_W - IDX_BITS;

  // State
  logic             valid_q [SETS][WAYS];
  logic [TAG_W-1:0] tag_q   [SETS][WAYS];
  logic [WAY_W-1:0] age_q   [SETS][WAYS];
  logic             valid_d [SETS][WAYS];
  logic [TAG_W-1:0] tag_d   [SETS][WAYS];
  logic [WAY_W-1:0] age_d   [SETS][WAYS];

  // Address split
  logic [IDX_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  assign req_tag = req_blk[BLK_W-1:IDX_BITS];

  if (SETS > 1) begin : g_idx
    assign set_idx = req_blk[IDX_BITS-1:0];
  end else begin : g_noidx
    assign set_idx = '0;
  end

  // Selected set
  logic             valid_row [WAYS];
  logic [TAG_W-1:0] tag_row   [WAYS];
  logic [WAY_W-1:0] age_row   [WAYS];
  logic [WAY_W-1:0] age_upd   [WAYS];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      valid_row[w] = valid_q[set_idx][w];
      tag_row[w]   = tag_q[set_idx][w];
      age_row[w]   = age_q[set_idx][w];
    end
  end

  logic [WAYS-1:0]  hit_vec;
  logic             hit;
  logic [WAY_W-1:0] hit_way;
  logic [WAY_W-1:0] victim_way;
  logic             victim_full;
  logic [WAY_W-1:0] chosen;
  logic             evict;
  logic [TAG_W-1:0] evict_tag;

  way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_match (
    .valid_row (valid_row),
    .tag_row   (tag_row),
    .req_tag   (req_tag),
    .hit_vec   (hit_vec),
    .hit       (hit),
    .hit_way   (hit_way)
  );

  victim_sel #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .valid_row   (valid_row),
    .age_row     (age_row),
    .victim_way  (victim_way),
    .victim_full (victim_full)
  );

  assign chosen = hit ? hit_way : victim_way;
  assign evict  = !hit && victim_full;

  always_comb begin
    evict_tag = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (victim_way == WAY_W'(w)) evict_tag = tag_row[w];
    end
  end

  lru_age #(.WAYS(WAYS), .WAY_W(WAY_W)) u_age (
    .age_row   (age_row),
    .touch_way (chosen),
    .age_next  (age_upd)
  );

  // Next state
  always_comb begin
    valid_d = valid_q;
    tag_d   = tag_q;
    age_d   = age_q;
    if (req_valid) begin
      for (int w = 0; w < WAYS; w++) begin
        age_d[set_idx][w] = age_upd[w];
        if (chosen == WAY_W'(w)) begin
          valid_d[set_idx][w] = 1'b1;
          tag_d[set_idx][w]   = req_tag;
        end
      end
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) begin
          valid_q[s][w] <= 1'b0;
          tag_q[s][w]   <= '0;
          age_q[s][w]   <= WAY_W'(w);
        end
      end
    end else if (req_valid) begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
      age_q   <= age_d;
    end
  end

  // Response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid     <= 1'b0;
      resp_hit       <= 1'b0;
      resp_way       <= '0;
      resp_evict     <= 1'b0;
      resp_evict_tag <= '0;
    end else begin
      resp_valid <= req_valid;
      if (req_valid) begin
        resp_hit       <= hit;
        resp_way       <= chosen;
        resp_evict     <= evict;
        resp_evict_tag <= evict ? BLK_W'(evict_tag) : '0;
      end
    end
  end

  // Assertions
  AST_RESP_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> resp_valid); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !resp_valid); // R8
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R3
  AST_HIT_KEEPS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_hit) |-> !resp_evict); // R5
  AST_EVICT_TAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_evict) |-> (resp_evict_tag == '0)); // R2
  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(hit_vec) || $changed(req_blk)); // R8
endmodule

// File: tb/tb_sa_lru_cache.sv
module tb_sa_lru_cache;
  localparam int CLK_PERIOD = 10;
  localparam int BLK_W      = 8;
  localparam int NVEC       = 5;

  logic             clk;
  logic             rst_n;
  logic             req_valid;
  logic [BLK_W-1:0] req_blk;

  // Three organisations: index 0 direct mapped, 1 two-way, 2 fully associative
  logic             rv   [3];
  logic             rh   [3];
  logic [1:0]       rw   [3];
  logic             re   [3];
  logic [BLK_W-1:0] rt   [3];

  logic             dm_way;
  logic             w2_way;
  logic [1:0]       fa_way;

  sa_lru_cache #(.BLOCKS(4), .WAYS(1), .BLK_W(BLK_W)) dut_dm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
    .resp_valid(rv[0]), .resp_hit(rh[0]), .resp_way(dm_way),
    .resp_evict(re[0]), .resp_evict_tag(rt[0]));

  sa_lru_cache #(.BLOCKS(4), .WAYS(2), .BLK_W(BLK_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
    .resp_valid(rv[1]), .resp_hit(rh[1]), .resp_way(w2_way),
    .resp_evict(re[1]), .resp_evict_tag(rt[1]));

  sa_lru_cache #(.BLOCKS(4), .WAYS(4), .BLK_W(BLK_W)) dut_fa (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_blk(req_blk),
    .resp_valid(rv[2]), .resp_hit(rh[2]), .resp_way(fa_way),
    .resp_evict(re[2]), .resp_evict_tag(rt[2]));

  assign rw[0] = {1'b0, dm_way};
  assign rw[1] = {1'b0, w2_way};
  assign rw[2] = fa_way;

  int tests_run;
  int tests_failed;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // Entry: blk[43:36], DM[35:24], 2W[23:12], FA[11:0]; each {hit, way[1:0], evict, tag[7:0]}
  localparam logic [43:0] VEC [NVEC] = '{
    {8'd0, 1'b0, 2'd0, 1'b0, 8'd0, 1'b0, 2'd0, 1'b0, 8'd0, 1'b0, 2'd0, 1'b0, 8'd0},
    {8'd8, 1'b0, 2'd0, 1'b1, 8'd0, 1'b0, 2'd1, 1'b0, 8'd0, 1'b0, 2'd1, 1'b0, 8'd0},
    {8'd0, 1'b0, 2'd0, 1'b1, 8'd2, 1'b1, 2'd0, 1'b0, 8'd0, 1'b1, 2'd0, 1'b0, 8'd0},
    {8'd6, 1'b0, 2'd0, 1'b0, 8'd0, 1'b0, 2'd1, 1'b1, 8'd4, 1'b0, 2'd2, 1'b0, 8'd0},
    {8'd8, 1'b0, 2'd0, 1'b1, 8'd0, 1'b0, 2'd0, 1'b1, 8'd0, 1'b1, 2'd1, 1'b0, 8'd0}
  };

  task automatic chk(input string rq, input string what, input int act, input int exp);
    tests_run++;
    if (act != exp) begin
      tests_failed++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_blk   = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive one request; sample the registered response on the following falling edge.
  task automatic access(input logic [BLK_W-1:0] blk);
    @(negedge clk);
    req_valid = 1'b1;
    req_blk   = blk;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_resp(input int d, input string rq, input int hit, input int way,
                             input int ev, input int tag);
    chk(rq, "resp_valid", int'(rv[d]), 1);
    chk(rq, "hit", int'(rh[d]), hit);
    chk(rq, "way", int'(rw[d]), way);
    chk(rq, "evict", int'(re[d]), ev);
    chk(rq, "evict_tag", int'(rt[d]), tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests_failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    int misses [3];
    tests_run    = 0;
    tests_failed = 0;
    rst_n        = 1'b0;
    req_valid    = 1'b0;
    req_blk      = '0;

    // R8: reset state
    do_reset();
    for (int d = 0; d < 3; d++) chk("R8", "resp_valid after reset", int'(rv[d]), 0);

    // R7, R1, R2, R3, R5: reference sequence on all three organisations
    for (int d = 0; d < 3; d++) misses[d] = 0;
    for (int i = 0; i < NVEC; i++) begin
      access(VEC[i][43:36]);
      for (int d = 0; d < 3; d++) begin
        logic [11:0] e;
        e = VEC[i][35 - 12*d -: 12];
        expect_resp(d, "R7", int'(e[11]), int'(e[10:9]), int'(e[8]), int'(e[7:0]));
        if (!rh[d]) misses[d]++;
      end
    end
    chk("R7", "direct-mapped misses", misses[0], 5);
    chk("R7", "two-way misses", misses[1], 4);
    chk("R7", "fully associative misses", misses[2], 3);

    // R4, R6, R5: fully associative fill order and recency
    do_reset();
    access(8'd5);  expect_resp(2, "R4", 0, 0, 0, 0);
    access(8'd9);  expect_resp(2, "R4", 0, 1, 0, 0);
    access(8'd3);  expect_resp(2, "R4", 0, 2, 0, 0);
    access(8'd7);  expect_resp(2, "R4", 0, 3, 0, 0);
    access(8'd5);  expect_resp(2, "R6", 1, 0, 0, 0);
    access(8'd11); expect_resp(2, "R5", 0, 1, 1, 9);
    access(8'd9);  expect_resp(2, "R6", 0, 2, 1, 3);

    // R1, R2, R5, R6: two-way sets kept apart
    do_reset();
    access(8'd2);  expect_resp(1, "R1", 0, 0, 0, 0);
    access(8'd3);  expect_resp(1, "R1", 0, 0, 0, 0);
    access(8'd4);  expect_resp(1, "R4", 0, 1, 0, 0);
    access(8'd5);  expect_resp(1, "R4", 0, 1, 0, 0);
    access(8'd2);  expect_resp(1, "R1", 1, 0, 0, 0);
    access(8'd3);  expect_resp(1, "R6", 1, 0, 0, 0);
    access(8'd6);  expect_resp(1, "R2", 0, 1, 1, 2);

    // R8: idle cycles with a conflicting block number leave state alone
    @(negedge clk);
    req_valid = 1'b0;
    req_blk   = 8'd8;
    repeat (3) begin
      @(negedge clk);
      chk("R8", "resp_valid while idle", int'(rv[1]), 0);
    end
    access(8'd2);  expect_resp(1, "R8", 1, 0, 0, 0);

    // R8: reset empties the cache
    do_reset();
    access(8'd2);  expect_resp(1, "R8", 0, 0, 0, 0);
    expect_resp(2, "R8", 0, 0, 0, 0);

    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule